// File: doc/BRIEF.md
# Multi-Standard Video Sync Generator

This block is the master timing source of a video encoder. It counts internal clocks along each line and lines along each frame. From those two counters it produces negative-polarity horizontal and vertical sync, a colour-burst gate, an active-picture gate, an odd/even field flag and a pixel clock at half the internal rate. The pixel clock can drive an external overlay source in lock with the picture.

Three television standards are supported, each in three clock plans: a disc plan and two graphics plans, one with a high clock and one with a low clock. Scanning is either interlaced or progressive. In progressive scan, a strap picks a field that is half a line shorter or half a line longer than an interlaced field. The strap inputs are sampled only at frame boundaries. The end of reset sets the timing reference: the first line of the first odd field begins on the first clock that sees reset low.

Top module: `vsg_sync_gen`

## Requirements
- R1: The standard is decoded from two straps. `std_sel`=0 gives NTSC. `std_sel`=1 with `pal_sel`=1 gives PAL. `std_sel`=1 with `pal_sel`=0 gives PAL60.
- R2: The line length in clocks is set by the standard and the clock plan. The plan is disc when `gfx_mode`=0, graphics-high when `gfx_mode`=1 and `gfx_hiclk`=1, and graphics-low otherwise. NTSC lines are 858 (disc) or 910 (either graphics plan). PAL lines are 864, 1135 or 908. PAL60 lines are 858, 1127 or 902.
- R3: `hsync_n` is low for line counts 0 up to, but not including, the sync-rise count. The sync-rise count is 64 in disc plans, 67 in graphics-low plans and in NTSC graphics, and 83 in PAL and PAL60 graphics-high.
- R4: `burst_gate` is high for line counts from the burst start up to, but not including, the burst end. It is held low while `vsync_n` is low. The (start, end) pairs are:
  - NTSC and PAL60 disc: (71,106)
  - PAL disc: (76,106)
  - NTSC graphics: (76,112)
  - PAL graphics-high: (100,140)
  - PAL graphics-low: (79,112)
  - PAL60 graphics-high: (94,139)
  - PAL60 graphics-low: (75,111)
- R5: `active_gate` is high from the data-start count to the end of the line, on lines whose index within the field is at least `VBLANK_LINES`. The data-start counts are:
  - NTSC and PAL60 disc: 128
  - PAL disc: 142
  - NTSC graphics: 135
  - PAL: 186 (graphics-high) and 149 (graphics-low)
  - PAL60: 166 (graphics-high) and 135 (graphics-low)
- R6: A frame has `NTSC_FRAME_LINES` (default 525) lines for NTSC and PAL60, and `PAL_FRAME_LINES` (default 625) lines for PAL, when `interlace`=1. With `interlace`=0 a frame is a single field of (frame lines − 1)/2 lines, plus one line when `add_half`=1.
- R7: `vsync_n` falls in the same cycle as `hsync_n` at the start of each frame. It stays low for 6 half-lines in NTSC and PAL60 and for 5 half-lines in PAL. In interlaced scan a second `vsync_n` pulse of the same length starts at mid-line, at half-line index equal to the frame line count.
- R8: `field_odd` is 1 from the frame start until the mid-line where the even field begins, and 0 for the rest of the frame. In progressive scan it stays 1.
- R9: While `rst` is high, `hsync_n`=1, `vsync_n`=1, `burst_gate`=0, `active_gate`=0, `pix_clk`=0 and `field_odd`=1. In the first cycle after the first clock edge that samples `rst` low, `hsync_n` and `vsync_n` are both low.
- R10: `pix_clk` toggles every cycle. The exception is the cycle in which `hsync_n` rises, where `pix_clk` is forced to 1.
- R11: A change of any strap takes effect only at the first line of the next frame. Lines already under way keep their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rst | input | 1 | Synchronous active-high reset; its release sets the timing reference |
| std_sel | input | 1 | 0 = NTSC, 1 = PAL family |
| pal_sel | input | 1 | With std_sel=1: 1 = PAL, 0 = PAL60 |
| gfx_mode | input | 1 | 0 = disc clock plan, 1 = graphics clock plan |
| gfx_hiclk | input | 1 | In the graphics plan, 1 selects the high-clock variant |
| interlace | input | 1 | 1 = interlaced, 0 = progressive |
| add_half | input | 1 | Progressive only: 1 = +0.5 line field, 0 = −0.5 line field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| burst_gate | output | 1 | High during the colour-burst window |
| active_gate | output | 1 | High during active picture |
| field_odd | output | 1 | 1 in the odd field, 0 in the even field |
| pix_clk | output | 1 | Half-rate pixel clock aligned to the hsync rising edge |

## Verification
Two situations are hard to reach from the ports:
- **Mid-frame strap change.** A strap must move in the middle of a frame and then be seen not to act until the frame wraps. The stimulus changes straps at random cycles inside long runs. A directed case switches NTSC disc to PAL graphics-high mid-frame and then measures the next line, which must still be 858 clocks long.
- **Even field and frame wrap.** With full-size frames, the even-field mid-line sync and the frame wrap lie hundreds of thousands of cycles away. The bench therefore shrinks the frame-line parameters to 21 and 25, so every standard and scan mode completes whole frames inside the run.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int H_W = 11;
    localparam int VS_HALF_525 = 6;
    localparam int VS_HALF_625 = 5;

    typedef logic [H_W-1:0] hcount_t;

    typedef enum logic [1:0] {
        STD_NTSC  = 2'd0,
        STD_PAL   = 2'd1,
        STD_PAL60 = 2'd2
    } tv_std_e;

    typedef enum logic [1:0] {
        PLAN_DISC   = 2'd0,
        PLAN_GFX_HI = 2'd1,
        PLAN_GFX_LO = 2'd2
    } clk_plan_e;

    typedef struct packed {
        tv_std_e   std;
        clk_plan_e plan;
        logic      interlace;
        logic      add_half;
    } scan_cfg_t;

    typedef struct packed {
        hcount_t len;
        hcount_t sync_rise;
        hcount_t burst_on;
        hcount_t burst_off;
        hcount_t data_on;
    } line_plan_t;

    // R1: standard decode from the two straps
    function automatic tv_std_e decode_std(logic std_sel, logic pal_sel);
        if (!std_sel)     return STD_NTSC;
        else if (pal_sel) return STD_PAL;
        else              return STD_PAL60;
    endfunction

    function automatic clk_plan_e decode_plan(logic gfx, logic hiclk);
        if (!gfx)       return PLAN_DISC;
        else if (hiclk) return PLAN_GFX_HI;
        else            return PLAN_GFX_LO;
    endfunction

    // R2 R3 R4 R5: horizontal landmarks per standard and clock plan
    function automatic line_plan_t plan_of(tv_std_e s, clk_plan_e p);
        line_plan_t r;
        unique case (s)
            STD_PAL: begin
                unique case (p)
                    PLAN_DISC:   r = '{11'd864,  11'd64, 11'd76,  11'd106, 11'd142};
                    PLAN_GFX_HI: r = '{11'd1135, 11'd83, 11'd100, 11'd140, 11'd186};
                    default:     r = '{11'd908,  11'd67, 11'd79,  11'd112, 11'd149};
                endcase
            end
            STD_PAL60: begin
                unique case (p)
                    PLAN_DISC:   r = '{11'd858,  11'd64, 11'd71,  11'd106, 11'd128};
                    PLAN_GFX_HI: r = '{11'd1127, 11'd83, 11'd94,  11'd139, 11'd166};
                    default:     r = '{11'd902,  11'd67, 11'd75,  11'd111, 11'd135};
                endcase
            end
            default: begin
                if (p == PLAN_DISC) r = '{11'd858, 11'd64, 11'd71, 11'd106, 11'd128};
                else                r = '{11'd910, 11'd67, 11'd76, 11'd112, 11'd135};
            end
        endcase
        return r;
    endfunction

    // R6: lines per frame (interlaced: two fields; progressive: one field)
    function automatic int frame_lines(scan_cfg_t c, int ntsc_fl, int pal_fl);
        int full;
        full = (c.std == STD_PAL) ? pal_fl : ntsc_fl;
        if (c.interlace) return full;
        else             return (full - 1) / 2 + int'(c.add_half);
    endfunction

    // R7: vertical sync length in half-lines
    function automatic int vsync_half_lines(tv_std_e s);
        return (s == STD_PAL) ? VS_HALF_625 : VS_HALF_525;
    endfunction

endpackage

// File: rtl/vsg_mode_latch.sv
module vsg_mode_latch
    import vsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      std_sel,
    input  logic      pal_sel,
    input  logic      gfx_mode,
    input  logic      gfx_hiclk,
    input  logic      interlace,
    input  logic      add_half,
    output scan_cfg_t cfg
);

    scan_cfg_t cfg_next;

    always_comb begin
        cfg_next.std       = decode_std(std_sel, pal_sel);
        cfg_next.plan      = decode_plan(gfx_mode, gfx_hiclk);
        cfg_next.interlace = interlace;
        cfg_next.add_half  = add_half;
    end

    // R11: straps are sampled only in reset, at start-up and at the frame wrap
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg <= cfg_next;
        end
    end

endmodule

// File: rtl/vsg_counter.sv
module vsg_counter
    import vsg_pkg::*;
#(
    parameter int NTSC_FRAME_LINES = 525,
    parameter int PAL_FRAME_LINES  = 625,
    parameter int V_W              = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  scan_cfg_t      cfg,
    output hcount_t        h_cnt,
    output logic [V_W-1:0] ln_cnt,
    output logic           running,
    output logic           load
);

    line_plan_t lp;
    logic       line_end;
    logic       frame_wrap;
    int         fl;

    always_comb begin
        lp         = plan_of(cfg.std, cfg.plan);
        fl         = frame_lines(cfg, NTSC_FRAME_LINES, PAL_FRAME_LINES);
        line_end   = (h_cnt == lp.len - hcount_t'(1));
        frame_wrap = running && line_end && (ln_cnt == V_W'(fl - 1));
        load       = !running || frame_wrap;
    end

    // R9: counters hold at zero through reset; the first edge after release
    // starts the reference line at count zero
    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt   <= '0;
            ln_cnt  <= '0;
            running <= 1'b0;
        end else if (!running) begin
            running <= 1'b1;
        end else if (line_end) begin
            h_cnt  <= '0;
            ln_cnt <= frame_wrap ? '0 : ln_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int NTSC_FRAME_LINES = 525,
    parameter int PAL_FRAME_LINES  = 625,
    parameter int VBLANK_LINES     = 20,
    parameter int V_W              = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  scan_cfg_t      cfg,
    input  hcount_t        h_cnt,
    input  logic [V_W-1:0] ln_cnt,
    input  logic           running,
    output logic           hsync_n,
    output logic           vsync_n,
    output logic           burst_gate,
    output logic           active_gate,
    output logic           field_odd,
    output logic           pix_clk
);

    line_plan_t lp;
    logic       in_sync;
    logic       vs_act;
    logic       even_f;
    logic       in_burst;
    logic       in_data;
    int         half_i;
    int         pos_i;
    int         full_i;
    int         vsl_i;
    int         fline_i;

    always_comb begin
        lp     = plan_of(cfg.std, cfg.plan);
        half_i = int'(lp.len) / 2;
        full_i = (cfg.std == STD_PAL) ? PAL_FRAME_LINES : NTSC_FRAME_LINES;
        vsl_i  = vsync_half_lines(cfg.std);
        // half-line index within the frame
        pos_i  = int'(ln_cnt) * 2 + ((int'(h_cnt) >= half_i) ? 1 : 0);
        // R8: even field begins at mid-line of the middle line
        even_f = cfg.interlace && (pos_i >= full_i);
        // R7: odd pulse at frame start, even pulse at the mid-line
        vs_act = (pos_i < vsl_i) ||
                 (cfg.interlace && (pos_i >= full_i) && (pos_i < full_i + vsl_i));
        fline_i  = even_f ? int'(ln_cnt) - full_i / 2 : int'(ln_cnt);
        // R3
        in_sync  = (h_cnt < lp.sync_rise);
        // R4
        in_burst = (h_cnt >= lp.burst_on) && (h_cnt < lp.burst_off) && !vs_act;
        // R5
        in_data  = (h_cnt >= lp.data_on) && (fline_i >= VBLANK_LINES);

        hsync_n     = !(running && in_sync);
        vsync_n     = !(running && vs_act);
        burst_gate  = running && in_burst;
        active_gate = running && in_data;
        field_odd   = !(running && even_f);
    end

    // R10: free toggle, re-phased so it rises together with hsync_n
    always_ff @(posedge clk) begin
        if (rst || !running) begin
            pix_clk <= 1'b0;
        end else if (h_cnt == lp.sync_rise - hcount_t'(1)) begin
            pix_clk <= 1'b1;
        end else begin
            pix_clk <= ~pix_clk;
        end
    end

endmodule

// File: rtl/vsg_sync_gen.sv
module vsg_sync_gen
    import vsg_pkg::*;
#(
    parameter int NTSC_FRAME_LINES = 525,
    parameter int PAL_FRAME_LINES  = 625,
    parameter int VBLANK_LINES     = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic std_sel,
    input  logic pal_sel,
    input  logic gfx_mode,
    input  logic gfx_hiclk,
    input  logic interlace,
    input  logic add_half,
    output logic hsync_n,
    output logic vsync_n,
    output logic burst_gate,
    output logic active_gate,
    output logic field_odd,
    output logic pix_clk
);

    localparam int MAX_FL = (PAL_FRAME_LINES > NTSC_FRAME_LINES) ? PAL_FRAME_LINES : NTSC_FRAME_LINES;
    localparam int V_W    = $clog2(MAX_FL + 1);

    scan_cfg_t      cfg;
    hcount_t        h_cnt;
    logic [V_W-1:0] ln_cnt;
    logic           running;
    logic           load;

    vsg_mode_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .std_sel   (std_sel),
        .pal_sel   (pal_sel),
        .gfx_mode  (gfx_mode),
        .gfx_hiclk (gfx_hiclk),
        .interlace (interlace),
        .add_half  (add_half),
        .cfg       (cfg)
    );

    vsg_counter #(
        .NTSC_FRAME_LINES (NTSC_FRAME_LINES),
        .PAL_FRAME_LINES  (PAL_FRAME_LINES),
        .V_W              (V_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .h_cnt   (h_cnt),
        .ln_cnt  (ln_cnt),
        .running (running),
        .load    (load)
    );

    vsg_decode #(
        .NTSC_FRAME_LINES (NTSC_FRAME_LINES),
        .PAL_FRAME_LINES  (PAL_FRAME_LINES),
        .VBLANK_LINES     (VBLANK_LINES),
        .V_W              (V_W)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .h_cnt       (h_cnt),
        .ln_cnt      (ln_cnt),
        .running     (running),
        .hsync_n     (hsync_n),
        .vsync_n     (vsync_n),
        .burst_gate  (burst_gate),
        .active_gate (active_gate),
        .field_odd   (field_odd),
        .pix_clk     (pix_clk)
    );

endmodule

// File: rtl/vsg_sync_chk.sv
module vsg_sync_chk
    import vsg_pkg::*;
#(
    parameter int V_W = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           hsync_n,
    input logic           vsync_n,
    input logic           burst_gate,
    input logic           active_gate,
    input logic           field_odd,
    input logic           pix_clk,
    input logic           running,
    input scan_cfg_t      cfg,
    input hcount_t        h_cnt,
    input logic [V_W-1:0] ln_cnt
);

    // R4
    burst_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
        burst_gate |-> hsync_n);

    // R5
    data_after_burst_chk: assert property (@(posedge clk) disable iff (rst)
        active_gate |-> !burst_gate);

    // R7
    odd_vsync_with_hsync_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(vsync_n) && field_odd) |-> !hsync_n);

    // R10
    pix_rise_at_hsync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> pix_clk);

    // R10
    pix_toggles_chk: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && $stable(pix_clk)) |-> $rose(hsync_n));

    // R11
    cfg_at_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> (h_cnt == '0 && ln_cnt == '0));

endmodule

bind vsg_sync_gen vsg_sync_chk #(.V_W(V_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .burst_gate  (burst_gate),
    .active_gate (active_gate),
    .field_odd   (field_odd),
    .pix_clk     (pix_clk),
    .running     (running),
    .cfg         (cfg),
    .h_cnt       (h_cnt),
    .ln_cnt      (ln_cnt)
);

// File: tb/sim_vsg_sync_gen.sv
module sim_vsg_sync_gen;

    localparam int NFL = 21;
    localparam int PFL = 25;
    localparam int VBL = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_sel = 1'b0, pal_sel = 1'b0, gfx_mode = 1'b0, gfx_hiclk = 1'b0;
    logic interlace = 1'b1, add_half = 1'b0;
    logic hsync_n, vsync_n, burst_gate, active_gate, field_odd, pix_clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    always #5 clk = ~clk;

    vsg_sync_gen #(
        .NTSC_FRAME_LINES (NFL),
        .PAL_FRAME_LINES  (PFL),
        .VBLANK_LINES     (VBL)
    ) u0 (
        .clk(clk), .rst(rst), .std_sel(std_sel), .pal_sel(pal_sel),
        .gfx_mode(gfx_mode), .gfx_hiclk(gfx_hiclk), .interlace(interlace),
        .add_half(add_half), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .burst_gate(burst_gate), .active_gate(active_gate),
        .field_odd(field_odd), .pix_clk(pix_clk)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Standard code: 0 NTSC, 1 PAL, 2 PAL60 (R1)
    function automatic int std_of(logic s, logic p);
        if (!s) return 0;
        return p ? 1 : 2;
    endfunction

    // Plan code: 0 disc, 1 graphics-high, 2 graphics-low (R2)
    function automatic int plan_of_b(logic g, logic hi);
        if (!g) return 0;
        return hi ? 1 : 2;
    endfunction

    // k: 0 length, 1 sync rise, 2 burst start, 3 burst end, 4 data start
    function automatic int tbl(int s, int p, int k);
        int v[5];
        if (s == 1) begin
            if (p == 0)      v = '{864, 64, 76, 106, 142};
            else if (p == 1) v = '{1135, 83, 100, 140, 186};
            else             v = '{908, 67, 79, 112, 149};
        end else if (s == 2) begin
            if (p == 0)      v = '{858, 64, 71, 106, 128};
            else if (p == 1) v = '{1127, 83, 94, 139, 166};
            else             v = '{902, 67, 75, 111, 135};
        end else begin
            if (p == 0)      v = '{858, 64, 71, 106, 128};
            else             v = '{910, 67, 76, 112, 135};
        end
        return v[k];
    endfunction

    function automatic int frame_of(int s, int il, int ah);
        int full;
        full = (s == 1) ? PFL : NFL;
        return il ? full : (full - 1) / 2 + ah;
    endfunction

    // Reference state
    bit m_run;
    int m_h, m_ln, m_s, m_p, m_il, m_ah;
    bit m_pix;

    always @(posedge clk) begin
        if (rst || !m_run) begin
            m_run <= !rst;
            m_h   <= 0;
            m_ln  <= 0;
            m_pix <= 1'b0;
            m_s   <= std_of(std_sel, pal_sel);
            m_p   <= plan_of_b(gfx_mode, gfx_hiclk);
            m_il  <= int'(interlace);
            m_ah  <= int'(add_half);
        end else begin
            m_pix <= (m_h == tbl(m_s, m_p, 1) - 1) ? 1'b1 : ~m_pix;
            if (m_h == tbl(m_s, m_p, 0) - 1) begin
                m_h <= 0;
                if (m_ln == frame_of(m_s, m_il, m_ah) - 1) begin
                    m_ln <= 0;
                    m_s  <= std_of(std_sel, pal_sel);
                    m_p  <= plan_of_b(gfx_mode, gfx_hiclk);
                    m_il <= int'(interlace);
                    m_ah <= int'(add_half);
                end else begin
                    m_ln <= m_ln + 1;
                end
            end else begin
                m_h <= m_h + 1;
            end
        end
    end

    // Per-cycle comparison and line/frame measurement
    bit prev_hs = 1'b1, prev_vs = 1'b1;
    int hcnt_meas = 0, exp_line = 0, lcount = 0, exp_frame = 0;
    bit have_l = 1'b0, have_f = 1'b0;

    always @(negedge clk) begin
        if (cmp_en) begin
            int len, half, full, pos, vsl, fl;
            bit vs, even, e_hs, e_vs, e_bg, e_ag, e_fo;
            len  = tbl(m_s, m_p, 0);
            half = len / 2;
            full = (m_s == 1) ? PFL : NFL;
            vsl  = (m_s == 1) ? 5 : 6;
            pos  = m_ln * 2 + ((m_h >= half) ? 1 : 0);
            even = (m_il != 0) && pos >= full;
            vs   = (pos < vsl) || ((m_il != 0) && pos >= full && pos < full + vsl);
            fl   = even ? m_ln - full / 2 : m_ln;
            e_hs = !(m_run && m_h < tbl(m_s, m_p, 1));
            e_vs = !(m_run && vs);
            e_bg = m_run && !vs && m_h >= tbl(m_s, m_p, 2) && m_h < tbl(m_s, m_p, 3);
            e_ag = m_run && m_h >= tbl(m_s, m_p, 4) && fl >= VBL;
            e_fo = !(m_run && even);
            check(hsync_n == e_hs, "R3 hsync_n", int'(hsync_n), int'(e_hs));
            check(vsync_n == e_vs, "R7 vsync_n", int'(vsync_n), int'(e_vs));
            check(burst_gate == e_bg, "R4 burst_gate", int'(burst_gate), int'(e_bg));
            check(active_gate == e_ag, "R5 active_gate", int'(active_gate), int'(e_ag));
            check(field_odd == e_fo, "R8 field_odd", int'(field_odd), int'(e_fo));
            check(pix_clk == m_pix, "R10 pix_clk", int'(pix_clk), int'(m_pix));

            if (rst) begin
                have_l = 1'b0;
                have_f = 1'b0;
            end else if (prev_hs && !hsync_n) begin
                if (have_l) check(hcnt_meas == exp_line, "R1 R2 line length", hcnt_meas, exp_line);
                exp_line  = len;
                hcnt_meas = 1;
                have_l    = 1'b1;
                if (prev_vs && !vsync_n) begin
                    if (have_f) check(lcount == exp_frame, "R6 frame lines", lcount, exp_frame);
                    exp_frame = frame_of(m_s, m_il, m_ah);
                    lcount    = 1;
                    have_f    = 1'b1;
                end else begin
                    lcount++;
                end
            end else begin
                hcnt_meas++;
            end
            prev_hs = hsync_n;
            prev_vs = vsync_n;
        end
    end

    task automatic straps(logic s, logic p, logic g, logic hi, logic il, logic ah);
        std_sel = s; pal_sel = p; gfx_mode = g; gfx_hiclk = hi;
        interlace = il; add_half = ah;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R9: idle outputs during reset
        check(hsync_n && vsync_n && !burst_gate && !active_gate && !pix_clk && field_odd,
              "R9 idle in reset", {hsync_n, vsync_n, burst_gate, active_gate, pix_clk, field_odd},
              6'b110001);
        rst = 1'b0;
        @(negedge clk);
        // R9: first cycle after release starts the reference line
        check(!hsync_n && !vsync_n, "R9 first cycle syncs low", {hsync_n, vsync_n}, 0);
    endtask

    task automatic measure_line(output int n);
        n = 0;
        while (!(hsync_n == 1'b0 && prev_hs == 1'b1)) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!(hsync_n == 1'b0 && prev_hs == 1'b1)) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        @(posedge clk);
        cmp_en = 1'b1;

        // NTSC disc interlaced: one full frame
        straps(0, 0, 0, 0, 1, 0);
        do_reset();
        repeat (NFL * 858 + 1000) @(negedge clk);

        // R11: switch to PAL graphics-high in mid-frame; current line keeps 858
        straps(1, 1, 1, 1, 1, 0);
        measure_line(n);
        check(n == 858, "R11 old timing kept mid-frame", n, 858);
        repeat (PFL * 1135 + 2000) @(negedge clk);
        measure_line(n);
        check(n == 1135, "R11 R2 new timing after wrap", n, 1135);

        // PAL60 graphics-low progressive, both field lengths (R6)
        straps(1, 0, 1, 0, 0, 0);
        do_reset();
        repeat (2 * 10 * 902 + 500) @(negedge clk);
        add_half = 1'b1;
        repeat (2 * 11 * 902 + 1000) @(negedge clk);

        // Random strap sets with mid-run changes
        for (int seg = 0; seg < 4; seg++) begin
            straps($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                   $urandom % 2, $urandom % 2);
            if ($urandom % 2) do_reset();
            for (int c = 0; c < 14000; c++) begin
                @(negedge clk);
                if ($urandom % 4000 == 0)
                    straps($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                           $urandom % 2, $urandom % 2);
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule